// File: doc/BRIEF.md
# Half-Bridge Deadtime and Blanking Generator

This block turns one PWM demand bit into two gate enables for a single half bridge, one for the high-side switch and one for the low-side switch. The two never conduct together. On every change of demand the switch that is on is dropped at once, and the opposite switch is raised only after a programmable deadtime in which both are off. Each time a switch turns on, a blanking window of the same length opens, and the overcurrent comparator input is masked while it is open.

The timing comes from a 2-bit rate code, counted in system clock cycles (16 MHz nominal). The code is captured only while the bridge is disabled, so it never changes in the middle of a switching sequence. An overcurrent seen outside blanking latches a fault that holds both gates off until a clear pulse. Dropping the enable also forces both gates off. The bridge comes out of reset disabled, with both gates off.

Top module: `half_bridge_dt_gen`

## Requirements
- R1: After reset both gate enables, the blanking flag and the fault flag are low.
- R2: The deadtime, counted as whole clock cycles with both gates low before the opposite gate rises, is selected by the rate code: 2'b00 gives 4 cycles, 2'b11 gives 6, 2'b10 gives 10 and 2'b01 gives 14 (defaults at 16 MHz).
- R3: When the demand no longer matches the conducting gate, that gate goes low at the first clock edge that samples the new demand.
- R4: The high-side and low-side gate enables are never high in the same cycle.
- R5: The blanking flag rises at the same edge as a gate enable and stays high for exactly the deadtime cycle count of the current rate code.
- R6: An overcurrent input that is high while the blanking flag is high does not set the fault flag.
- R7: An overcurrent input that is high at a clock edge while the bridge is enabled and blanking is low sets the fault flag at that edge and drives both gates low at the same edge. The flag and the off state hold, whatever the demand does, until a clear.
- R8: A clear pulse lowers the fault flag. After that the bridge goes through a full deadtime before the demanded gate rises. If a new overcurrent and a clear arrive in the same cycle, the fault flag stays set.
- R9: With the enable low, both gates and the blanking flag are low after the next edge. When the enable rises, the demanded gate rises after a full deadtime.
- R10: The rate code is captured only while the enable is low. A change of the code while the bridge is enabled leaves the deadtime unchanged.
- R11: A change of demand during a deadtime restarts the full deadtime count toward the newest demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bridge_en | input | 1 | Bridge enable; low forces both gates off and lets the rate code be captured |
| rate_sel | input | 2 | Deadtime and blanking rate code |
| pwm_dem | input | 1 | PWM demand: 1 asks for the high side, 0 for the low side |
| oc_in | input | 1 | Raw overcurrent comparator input |
| fault_clr | input | 1 | Clear pulse for the latched fault |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| blank_act | output | 1 | Blanking window active |
| oc_fault | output | 1 | Latched qualified overcurrent fault |

## Verification
A wrong deadtime counter value, or a wrong decode of the rate code, shows as a gap of the wrong length between one gate falling and the other rising. The bench measures that gap for every code in both directions, so the error appears within one switching event. A blanking counter that is off by any amount shows as a window of the wrong length, or as an overcurrent pulse that latches although it was timed to fall inside the window. A phase register stuck in a conducting state shows within one cycle, either as overlapping gates or as a gate that stays high after a fault or after the enable drops.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_DEAD = 2'd1,
    PH_HI   = 2'd2,
    PH_LO   = 2'd3
  } hb_phase_e;

endpackage

// File: rtl/hb_rate_latch.sv
module hb_rate_latch #(
  parameter int DT_C00 = 4,
  parameter int DT_C01 = 14,
  parameter int DT_C10 = 10,
  parameter int DT_C11 = 6,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bridge_en,
  input  logic [1:0]       rate_sel,
  output logic [CNT_W-1:0] dt_cycles
);

  logic [1:0] sel_q;
  logic [1:0] sel_nx;
  logic       sel_ce;

  // capture only while the bridge is idle
  assign sel_ce = ~bridge_en;
  assign sel_nx = rate_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
    end else if (sel_ce) begin
      sel_q <= sel_nx;
    end
  end

  // non-monotonic code to cycle count map
  always_comb begin
    case (sel_q)
      2'b00:   dt_cycles = CNT_W'(DT_C00);
      2'b01:   dt_cycles = CNT_W'(DT_C01);
      2'b10:   dt_cycles = CNT_W'(DT_C10);
      default: dt_cycles = CNT_W'(DT_C11);
    endcase
  end

  assert_code_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en |=> $stable(dt_cycles));

  assert_dt_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dt_cycles != '0);

endmodule

// File: rtl/hb_phase_fsm.sv
module hb_phase_fsm
  import hb_dt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bridge_en,
  input  logic             pwm_dem,
  input  logic             halt,
  input  logic [CNT_W-1:0] dt_cycles,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             turn_on,
  output logic             go_off
);

  localparam logic [CNT_W-1:0] RUN_SAT = {CNT_W{1'b1}};

  hb_phase_e        state_q, state_nx;
  logic [CNT_W-1:0] dcnt_q, dcnt_nx;
  logic             tgt_q, tgt_nx;
  logic             ghi_q, glo_q;
  logic             ghi_nx, glo_nx;
  logic [CNT_W-1:0] dt_load;

  assign dt_load = dt_cycles - CNT_W'(1);

  always_comb begin
    state_nx = state_q;
    dcnt_nx  = dcnt_q;
    tgt_nx   = tgt_q;
    if (!bridge_en || halt) begin
      state_nx = PH_OFF;
    end else begin
      case (state_q)
        PH_OFF: begin
          state_nx = PH_DEAD;
          tgt_nx   = pwm_dem;
          dcnt_nx  = dt_load;
        end
        PH_DEAD: begin
          if (pwm_dem != tgt_q) begin
            tgt_nx  = pwm_dem;
            dcnt_nx = dt_load;
          end else if (dcnt_q == '0) begin
            state_nx = tgt_q ? PH_HI : PH_LO;
          end else begin
            dcnt_nx = dcnt_q - CNT_W'(1);
          end
        end
        PH_HI: begin
          if (!pwm_dem) begin
            state_nx = PH_DEAD;
            tgt_nx   = 1'b0;
            dcnt_nx  = dt_load;
          end
        end
        default: begin
          if (pwm_dem) begin
            state_nx = PH_DEAD;
            tgt_nx   = 1'b1;
            dcnt_nx  = dt_load;
          end
        end
      endcase
    end
  end

  assign ghi_nx  = (state_nx == PH_HI);
  assign glo_nx  = (state_nx == PH_LO);
  assign turn_on = (state_q == PH_DEAD) && (ghi_nx || glo_nx);
  assign go_off  = (state_nx == PH_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_OFF;
      dcnt_q  <= '0;
      tgt_q   <= 1'b0;
      ghi_q   <= 1'b0;
      glo_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      dcnt_q  <= dcnt_nx;
      tgt_q   <= tgt_nx;
      ghi_q   <= ghi_nx;
      glo_q   <= glo_nx;
    end
  end

  assign gate_hi = ghi_q;
  assign gate_lo = glo_q;

  // consecutive both-off cycles, used only by the deadtime check
  logic [CNT_W-1:0] off_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run_q <= '0;
    end else if (ghi_q || glo_q) begin
      off_run_q <= '0;
    end else if (off_run_q != RUN_SAT) begin
      off_run_q <= off_run_q + CNT_W'(1);
    end
  end

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  assert_deadtime_met_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run_q >= dt_cycles));

  assert_drop_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi && !pwm_dem) || (gate_lo && pwm_dem)) |=> !(gate_hi || gate_lo));

  assert_disable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_en |=> (!gate_hi && !gate_lo));

  assert_halt_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!gate_hi && !gate_lo));

endmodule

// File: rtl/hb_blank_timer.sv
module hb_blank_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic [CNT_W-1:0] dt_cycles,
  output logic             blank_act
);

  logic             act_q, act_nx;
  logic [CNT_W-1:0] bcnt_q, bcnt_nx;

  always_comb begin
    act_nx  = act_q;
    bcnt_nx = bcnt_q;
    if (clear) begin
      act_nx  = 1'b0;
      bcnt_nx = '0;
    end else if (start) begin
      act_nx  = 1'b1;
      bcnt_nx = dt_cycles - CNT_W'(1);
    end else if (act_q) begin
      if (bcnt_q == '0) begin
        act_nx = 1'b0;
      end else begin
        bcnt_nx = bcnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      bcnt_q <= '0;
    end else begin
      act_q  <= act_nx;
      bcnt_q <= bcnt_nx;
    end
  end

  assign blank_act = act_q;

  assert_blank_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clear) |=> blank_act);

  assert_blank_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !blank_act);

endmodule

// File: rtl/hb_oc_guard.sv
module hb_oc_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic bridge_en,
  input  logic blank_act,
  input  logic oc_in,
  input  logic fault_clr,
  output logic oc_trip,
  output logic oc_fault
);

  logic fault_q, fault_nx;

  assign oc_trip = oc_in && bridge_en && !blank_act;

  always_comb begin
    fault_nx = fault_q;
    if (oc_trip) begin
      fault_nx = 1'b1;
    end else if (fault_clr) begin
      fault_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_nx;
    end
  end

  assign oc_fault = fault_q;

  assert_masked_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_act && !oc_fault) |=> !oc_fault);

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fault && !fault_clr) |=> oc_fault);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_in && bridge_en && !blank_act) |=> oc_fault);

endmodule

// File: rtl/half_bridge_dt_gen.sv
module half_bridge_dt_gen #(
  parameter int DT_C00 = 4,
  parameter int DT_C01 = 14,
  parameter int DT_C10 = 10,
  parameter int DT_C11 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bridge_en,
  input  logic [1:0] rate_sel,
  input  logic       pwm_dem,
  input  logic       oc_in,
  input  logic       fault_clr,
  output logic       gate_hi,
  output logic       gate_lo,
  output logic       blank_act,
  output logic       oc_fault
);

  localparam int MAX_A  = (DT_C00 > DT_C01) ? DT_C00 : DT_C01;
  localparam int MAX_B  = (DT_C10 > DT_C11) ? DT_C10 : DT_C11;
  localparam int MAX_DT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_DT + 1);

  logic [CNT_W-1:0] dt_cycles;
  logic             turn_on;
  logic             go_off;
  logic             oc_trip;
  logic             halt;

  hb_rate_latch #(
    .DT_C00 (DT_C00),
    .DT_C01 (DT_C01),
    .DT_C10 (DT_C10),
    .DT_C11 (DT_C11),
    .CNT_W  (CNT_W)
  ) rate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bridge_en (bridge_en),
    .rate_sel  (rate_sel),
    .dt_cycles (dt_cycles)
  );

  assign halt = oc_fault || oc_trip;

  hb_phase_fsm #(
    .CNT_W (CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bridge_en (bridge_en),
    .pwm_dem   (pwm_dem),
    .halt      (halt),
    .dt_cycles (dt_cycles),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .turn_on   (turn_on),
    .go_off    (go_off)
  );

  hb_blank_timer #(
    .CNT_W (CNT_W)
  ) blank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (turn_on),
    .clear     (go_off),
    .dt_cycles (dt_cycles),
    .blank_act (blank_act)
  );

  hb_oc_guard guard_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bridge_en (bridge_en),
    .blank_act (blank_act),
    .oc_in     (oc_in),
    .fault_clr (fault_clr),
    .oc_trip   (oc_trip),
    .oc_fault  (oc_fault)
  );

  assert_fault_gates_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |-> (!gate_hi && !gate_lo));

  assert_blank_with_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> blank_act);

endmodule

// File: tb/half_bridge_dt_gen_tb_top.sv
module half_bridge_dt_gen_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk;
  logic       rst_n;
  logic       bridge_en;
  logic [1:0] rate_sel;
  logic       pwm_dem;
  logic       oc_in;
  logic       fault_clr;
  logic       gate_hi;
  logic       gate_lo;
  logic       blank_act;
  logic       oc_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  half_bridge_dt_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bridge_en (bridge_en),
    .rate_sel  (rate_sel),
    .pwm_dem   (pwm_dem),
    .oc_in     (oc_in),
    .fault_clr (fault_clr),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .blank_act (blank_act),
    .oc_fault  (oc_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_n(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b11:   return 6;
      2'b10:   return 10;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // counts observations with both gates low, stops at the first with a gate high
  task automatic count_off(output int n);
    n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      chk(!(gate_hi && gate_lo), "R4", "gates overlap", 1, 0);
      if (!gate_hi && !gate_lo) n++;
      else break;
    end
  endtask

  task automatic count_blank(output int n);
    n = 0;
    while (blank_act && n < 80) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, m;
    rst_n = 1'b0; bridge_en = 1'b0; rate_sel = 2'b00;
    pwm_dem = 1'b0; oc_in = 1'b0; fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!gate_hi && !gate_lo, "R1", "gates after reset", int'(gate_hi | gate_lo), 0);
    chk(!blank_act, "R1", "blank after reset", int'(blank_act), 0);
    chk(!oc_fault, "R1", "fault after reset", int'(oc_fault), 0);

    for (int c = 0; c < 4; c++) begin
      int nn;
      nn = exp_n(2'(c));
      bridge_en = 1'b0; rate_sel = 2'(c); pwm_dem = 1'b1;
      repeat (2) @(negedge clk);
      bridge_en = 1'b1;
      count_off(n);
      chk(n == nn, "R9", "deadtime after enable", n, nn);
      chk(gate_hi && !gate_lo, "R9", "demanded high side on", int'(gate_hi), 1);
      count_blank(m);
      chk(m == nn, "R5", "blank length high side", m, nn);
      repeat (3) @(negedge clk);

      // high -> low
      pwm_dem = 1'b0;
      @(negedge clk);
      chk(!gate_hi, "R3", "high side dropped at first edge", int'(gate_hi), 0);
      count_off(m);
      chk(m + 1 == nn, "R2", "deadtime high to low", m + 1, nn);
      chk(gate_lo && !gate_hi, "R2", "low side on", int'(gate_lo), 1);
      count_blank(m);
      chk(m == nn, "R5", "blank length low side", m, nn);
      repeat (2) @(negedge clk);

      // low -> high, with an overcurrent pulse inside the blanking window
      pwm_dem = 1'b1;
      @(negedge clk);
      chk(!gate_lo, "R3", "low side dropped at first edge", int'(gate_lo), 0);
      count_off(m);
      chk(m + 1 == nn, "R2", "deadtime low to high", m + 1, nn);
      chk(blank_act, "R5", "blank at gate rise", int'(blank_act), 1);
      oc_in = 1'b1;
      repeat (nn - 1) @(negedge clk);
      oc_in = 1'b0;
      chk(!oc_fault, "R6", "overcurrent masked in blank", int'(oc_fault), 0);
      repeat (nn + 2) @(negedge clk);
      chk(!oc_fault && gate_hi, "R6", "gate kept after masked pulse", int'(gate_hi), 1);
      chk(!blank_act, "R5", "blank closed", int'(blank_act), 0);

      // unmasked overcurrent
      oc_in = 1'b1;
      @(negedge clk);
      chk(oc_fault, "R7", "fault set", int'(oc_fault), 1);
      chk(!gate_hi && !gate_lo, "R7", "gates off on fault", int'(gate_hi | gate_lo), 0);
      oc_in = 1'b0; pwm_dem = 1'b0;
      repeat (20) @(negedge clk);
      chk(oc_fault && !gate_hi && !gate_lo, "R7", "fault sticky, gates off",
          int'(oc_fault), 1);

      fault_clr = 1'b1;
      @(negedge clk);
      fault_clr = 1'b0;
      chk(!oc_fault, "R8", "fault cleared", int'(oc_fault), 0);
      count_off(n);
      chk(n == nn, "R8", "deadtime after clear", n, nn);
      chk(gate_lo, "R8", "low side on after clear", int'(gate_lo), 1);

      bridge_en = 1'b0;
      @(negedge clk);
      chk(!gate_hi && !gate_lo && !blank_act, "R9", "disable forces off",
          int'(gate_hi | gate_lo | blank_act), 0);
    end

    // code change while enabled is ignored
    bridge_en = 1'b0; rate_sel = 2'b00; pwm_dem = 1'b1;
    repeat (2) @(negedge clk);
    bridge_en = 1'b1;
    count_off(n);
    chk(n == 4, "R10", "deadtime with code 00", n, 4);
    repeat (8) @(negedge clk);
    rate_sel = 2'b01;
    pwm_dem  = 1'b0;
    count_off(n);
    chk(n == 4, "R10", "code change while enabled ignored", n, 4);
    chk(gate_lo, "R10", "low side on", int'(gate_lo), 1);
    repeat (8) @(negedge clk);

    // demand change during deadtime restarts the count
    pwm_dem = 1'b1;
    repeat (2) @(negedge clk);
    chk(!gate_hi && !gate_lo, "R11", "in deadtime", int'(gate_hi | gate_lo), 0);
    pwm_dem = 1'b0;
    count_off(n);
    chk(n == 4, "R11", "restarted deadtime", n, 4);
    chk(gate_lo && !gate_hi, "R11", "newest demand wins", int'(gate_lo), 1);
    repeat (8) @(negedge clk);

    // overcurrent and clear in the same cycle: set wins
    oc_in = 1'b1; fault_clr = 1'b1;
    @(negedge clk);
    oc_in = 1'b0; fault_clr = 1'b0;
    chk(oc_fault, "R8", "set beats clear", int'(oc_fault), 1);
    @(negedge clk);
    chk(oc_fault, "R8", "fault still held", int'(oc_fault), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule